// File: doc/BRIEF.md
# EEPROM Write-Protect Command Controller

This block sits on the target side of an I2C bus, next to a serial EEPROM. It receives the bus as decoded events: start, stop and complete bytes. It looks for the three write-protect commands, decides whether to acknowledge each byte of those commands, and holds the protection state that the memory array uses to refuse writes. All three commands are framed like an ordinary memory write: a start, an address byte with device code `0110` and the write bit, a word-address byte, a data byte and a stop. The word-address and data bytes are don't-care. A command is accepted only when the A0 pin is held at high voltage and the three address bits of the byte match the digital levels on the address pins.

The pin pattern on A2/A1 selects the command. A2 low and A1 low sets the software flag. A2 low and A1 high clears the software flag. A2 high and A1 low sets the permanent flag. Once the permanent flag is set, no command can remove it, and only a power-on reset clears it. The ordinary reset clears only the software flag.

The controller is a state machine with six states. `ST_IDLE` means no transaction. `ST_ADDR` waits for the address byte after a start. `ST_WORD` waits for the word-address byte. `ST_DATA` waits for the data byte. `ST_ARMED` means the data byte was acknowledged and the block waits for the stop. `ST_SKIP` ignores bytes until the next start. Its transitions are:
- **start**: any state goes to `ST_ADDR`.
- **stop**: any state goes to `ST_IDLE`; a stop in `ST_ARMED` also commits the command.
- **addr-accept**: `ST_ADDR` goes to `ST_WORD`.
- **addr-reject**: `ST_ADDR` goes to `ST_SKIP`, for a foreign code or a refused address.
- **byte-ok**: `ST_WORD` goes to `ST_DATA` and `ST_DATA` goes to `ST_ARMED`, while A0 is at high voltage.
- **byte-abort**: a byte without high voltage, or an extra byte in `ST_ARMED`, leads to `ST_SKIP`.
- **idle-byte**: a byte in `ST_IDLE` or `ST_SKIP` keeps the state.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: An address byte whose upper four bits are not `0110` produces no acknowledge strobe (`ack_vld` stays 0). No later byte of that transaction produces one either, and both flags stay unchanged.
- R2: Set-software command. The address byte is `0110_001_0`, the pins are A2=0 and A1=0, A0 is high and `a0_hv`=1, and permanent protect is clear. The address, word and data bytes are ACKed (`ack`=1), and `sw_wp` becomes 1 after the stop.
- R3: Clear command. The address byte is `0110_011_0`, the pins are A2=0, A1=1 and A0 high, and `a0_hv`=1. All three bytes are ACKed, `sw_wp` becomes 0 after the stop, and `perm_wp` keeps its value.
- R4: Set-permanent command. The address byte is `0110_101_0`, the pins are A2=1, A1=0 and A0 high, and `a0_hv`=1. All three bytes are ACKed, and `perm_wp` becomes 1 after the stop.
- R5: An address byte with code `0110` is NACKed (`ack_vld`=1, `ack`=0) in any of these cases: `a0_hv`=0; A0 is low; bits [3:1] differ from the pin levels {A2,A1,A0}; bit 0 (R/W) is 1; or A2=A1=1. The flags are then unchanged.
- R6: While `perm_wp`=1, the set-software and set-permanent address bytes are NACKed with no effect. The clear command is still ACKed and still clears `sw_wp`.
- R7: A command takes effect only on a stop that follows the ACKed data byte. A repeated start or a stop before that point leaves the flags unchanged. A fourth byte is NACKed and cancels the command.
- R8: A word or data byte received while `a0_hv`=0 is NACKed and cancels the command.
- R9: `wr_inhibit` is 1 exactly when `sw_wp` or `perm_wp` is 1.
- R10: `rst_n` low clears `sw_wp` and keeps `perm_wp`. `por_n` low clears both flags.
- R11: `ack_vld`/`ack` appear in the cycle after the clock edge that samples `byte_valid`. The flags change at the clock edge that samples the committing stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears both flags |
| rst_n | input | 1 | Functional reset, active low, clears the software flag |
| i2c_start | input | 1 | Start or repeated-start event, one cycle |
| i2c_stop | input | 1 | Stop event, one cycle |
| byte_valid | input | 1 | A complete byte is present on `byte_data` |
| byte_data | input | 8 | Received byte; for the address byte, bit 0 is R/W |
| pin_lvl | input | 3 | Digital levels of address pins {A2,A1,A0} |
| a0_hv | input | 1 | High voltage detected on A0 |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| sw_wp | output | 1 | Software write protect flag |
| perm_wp | output | 1 | Permanent write protect flag |
| wr_inhibit | output | 1 | Writes to the array are refused |

## Verification
Several properties are checked on every cycle. The permanent flag never falls outside power-on reset. The software flag moves only at a stop or a reset. It never rises while permanent protect is held. An acknowledge strobe follows a sampled byte and nothing else. A byte seen without high voltage is never ACKed. The bench scenarios are the only evidence for the address decode against each pin pattern, the cancelling effect of repeated starts, early stops and extra bytes, and the separation between the two reset inputs. Those scenarios mix directed cases with random transactions scored against a bench model.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int BYTE_W   = 8;
    localparam int CODE_W   = 4;
    localparam int PIN_W    = 3;
    localparam logic [CODE_W-1:0] WP_DEV_CODE = 4'b0110;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_SET_SW,
        CMD_CLR_SW,
        CMD_SET_PERM
    } wp_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WORD,
        ST_DATA,
        ST_ARMED,
        ST_SKIP
    } wp_state_e;

    // Command selected by the A2/A1 pin levels
    function automatic wp_cmd_e cmd_from_pins(input logic [1:0] a21);
        unique case (a21)
            2'b00:   return CMD_SET_SW;
            2'b01:   return CMD_CLR_SW;
            2'b10:   return CMD_SET_PERM;
            default: return CMD_NONE;
        endcase
    endfunction
endpackage

// File: rtl/wp_addr_decode.sv
module wp_addr_decode
    import wp_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int PW = PIN_W
) (
    input  logic [BW-1:0] addr_byte,
    input  logic [PW-1:0] pin_lvl,
    input  logic          a0_hv,
    input  logic          perm_wp,
    output logic          claimed,
    output logic          accept,
    output wp_cmd_e       cmd
);
    localparam int CODE_LSB = BW - CODE_W;

    logic    pins_ok;
    logic    blocked;
    wp_cmd_e sel;

    always_comb begin
        claimed = (addr_byte[BW-1:CODE_LSB] == WP_DEV_CODE);
        pins_ok = a0_hv && pin_lvl[0]
                  && (addr_byte[PW:1] == pin_lvl)
                  && !addr_byte[0];
        sel     = cmd_from_pins(pin_lvl[PW-1:1]);
        blocked = perm_wp && ((sel == CMD_SET_SW) || (sel == CMD_SET_PERM));
        accept  = claimed && pins_ok && (sel != CMD_NONE) && !blocked;
        cmd     = accept ? sel : CMD_NONE;
    end
endmodule

// File: rtl/wp_cmd_fsm.sv
module wp_cmd_fsm
    import wp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    i2c_start,
    input  logic    i2c_stop,
    input  logic    byte_valid,
    input  logic    a0_hv,
    input  logic    addr_claimed,
    input  logic    addr_accept,
    input  wp_cmd_e addr_cmd,
    output logic    ack_vld,
    output logic    ack,
    output logic    commit,
    output wp_cmd_e commit_cmd
);
    wp_state_e state, state_nx;
    wp_cmd_e   cmd_q;
    logic      byte_ev;
    logic      resp_vld;
    logic      resp_ack;

    assign byte_ev = byte_valid && !i2c_start && !i2c_stop;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cmd_q <= CMD_NONE;
        end else begin
            state <= state_nx;
            if (byte_ev && state == ST_ADDR && addr_accept)
                cmd_q <= addr_cmd;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        if (i2c_start) begin
            state_nx = ST_ADDR;
        end else if (i2c_stop) begin
            state_nx = ST_IDLE;
        end else if (byte_ev) begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_ADDR:  state_nx = addr_accept ? ST_WORD : ST_SKIP;
                ST_WORD:  state_nx = a0_hv ? ST_DATA : ST_SKIP;
                ST_DATA:  state_nx = a0_hv ? ST_ARMED : ST_SKIP;
                ST_ARMED: state_nx = ST_SKIP;
                ST_SKIP:  state_nx = ST_SKIP;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // response decision for the current byte
    always_comb begin
        resp_vld = 1'b0;
        resp_ack = 1'b0;
        if (byte_ev) begin
            unique case (state)
                ST_ADDR: begin
                    resp_vld = addr_claimed;
                    resp_ack = addr_accept;
                end
                ST_WORD, ST_DATA: begin
                    resp_vld = 1'b1;
                    resp_ack = a0_hv;
                end
                ST_ARMED: begin
                    resp_vld = 1'b1;
                    resp_ack = 1'b0;
                end
                default: begin
                    resp_vld = 1'b0;
                    resp_ack = 1'b0;
                end
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_vld <= 1'b0;
            ack     <= 1'b0;
        end else begin
            ack_vld <= resp_vld;
            ack     <= resp_vld && resp_ack;
        end
    end

    assign commit     = (state == ST_ARMED) && i2c_stop && !i2c_start;
    assign commit_cmd = cmd_q;
endmodule

// File: rtl/wp_flags.sv
module wp_flags
    import wp_pkg::*;
(
    input  logic    clk,
    input  logic    por_n,
    input  logic    sys_rst_n,
    input  logic    commit,
    input  wp_cmd_e commit_cmd,
    output logic    sw_wp,
    output logic    perm_wp
);
    // permanent flag: only power-on reset clears it
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            perm_wp <= 1'b0;
        else if (commit && commit_cmd == CMD_SET_PERM)
            perm_wp <= 1'b1;
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n)
            sw_wp <= 1'b0;
        else if (commit) begin
            unique case (commit_cmd)
                CMD_SET_SW: sw_wp <= 1'b1;
                CMD_CLR_SW: sw_wp <= 1'b0;
                default:    sw_wp <= sw_wp;
            endcase
        end
    end
endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
    import wp_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              i2c_start,
    input  logic              i2c_stop,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic [PIN_W-1:0]  pin_lvl,
    input  logic              a0_hv,
    output logic              ack_vld,
    output logic              ack,
    output logic              sw_wp,
    output logic              perm_wp,
    output logic              wr_inhibit
);
    logic    sys_rst_n;
    logic    claimed;
    logic    accept;
    logic    commit;
    wp_cmd_e dec_cmd;
    wp_cmd_e commit_cmd;

    assign sys_rst_n = rst_n && por_n;

    wp_addr_decode #(.BW(BYTE_W), .PW(PIN_W)) u_dec (
        .addr_byte (byte_data),
        .pin_lvl   (pin_lvl),
        .a0_hv     (a0_hv),
        .perm_wp   (perm_wp),
        .claimed   (claimed),
        .accept    (accept),
        .cmd       (dec_cmd)
    );

    wp_cmd_fsm u_fsm (
        .clk          (clk),
        .rst_n        (sys_rst_n),
        .i2c_start    (i2c_start),
        .i2c_stop     (i2c_stop),
        .byte_valid   (byte_valid),
        .a0_hv        (a0_hv),
        .addr_claimed (claimed),
        .addr_accept  (accept),
        .addr_cmd     (dec_cmd),
        .ack_vld      (ack_vld),
        .ack          (ack),
        .commit       (commit),
        .commit_cmd   (commit_cmd)
    );

    wp_flags u_flags (
        .clk        (clk),
        .por_n      (por_n),
        .sys_rst_n  (sys_rst_n),
        .commit     (commit),
        .commit_cmd (commit_cmd),
        .sw_wp      (sw_wp),
        .perm_wp    (perm_wp)
    );

    assign wr_inhibit = sw_wp || perm_wp;
endmodule

// File: rtl/wp_chk.sv
module wp_chk (
    input logic clk,
    input logic por_n,
    input logic rst_n,
    input logic i2c_start,
    input logic i2c_stop,
    input logic byte_valid,
    input logic a0_hv,
    input logic ack_vld,
    input logic ack,
    input logic sw_wp,
    input logic perm_wp
);
    // R10
    perm_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        perm_wp |=> perm_wp);

    // R7
    sw_moves_on_stop_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !$stable(sw_wp) |-> $past(i2c_stop));

    // R6
    no_sw_rise_under_perm_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(sw_wp) |-> !$past(perm_wp));

    // R11
    ack_follows_byte_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        ack_vld |-> $past(byte_valid));

    // R8
    no_ack_without_hv_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (byte_valid && !a0_hv && !i2c_start && !i2c_stop) |=> !ack);

    // R11
    ack_needs_vld_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        ack |-> ack_vld);
endmodule

bind eeprom_wp_ctrl wp_chk u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .rst_n      (rst_n),
    .i2c_start  (i2c_start),
    .i2c_stop   (i2c_stop),
    .byte_valid (byte_valid),
    .a0_hv      (a0_hv),
    .ack_vld    (ack_vld),
    .ack        (ack),
    .sw_wp      (sw_wp),
    .perm_wp    (perm_wp)
);

// File: tb/sim_eeprom_wp_ctrl.sv
`timescale 1ns/1ps
module sim_eeprom_wp_ctrl;
    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0;
    logic       i2c_start = 1'b0, i2c_stop = 1'b0, byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic [2:0] pin_lvl = 3'b000;
    logic       a0_hv = 1'b0;
    logic       ack_vld, ack, sw_wp, perm_wp, wr_inhibit;

    int checks = 0;
    int errors = 0;

    // bench model of protection state
    logic m_sw = 1'b0, m_perm = 1'b0;

    always #4 clk = ~clk;

    eeprom_wp_ctrl u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .i2c_start(i2c_start), .i2c_stop(i2c_stop),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .pin_lvl(pin_lvl), .a0_hv(a0_hv),
        .ack_vld(ack_vld), .ack(ack), .sw_wp(sw_wp),
        .perm_wp(perm_wp), .wr_inhibit(wr_inhibit)
    );

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_flags(input string tag);
        chk({tag, " sw_wp"}, sw_wp, m_sw);
        chk({tag, " perm_wp"}, perm_wp, m_perm);
        chk({"R9 ", tag, " wr_inhibit"}, wr_inhibit, m_sw | m_perm);
    endtask

    task automatic do_start();
        @(negedge clk); i2c_start = 1'b1;
        @(negedge clk); i2c_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); i2c_stop = 1'b1;
        @(negedge clk); i2c_stop = 1'b0;
    endtask

    // sends one byte, checks strobe and decision one cycle later (R11)
    task automatic send_byte(input logic [7:0] b, input logic exp_vld,
                             input logic exp_ack, input string tag);
        @(negedge clk); byte_valid = 1'b1; byte_data = b;
        @(negedge clk); byte_valid = 1'b0;
        chk({"R11 ", tag, " ack_vld"}, ack_vld, exp_vld);
        chk({tag, " ack"}, ack, exp_ack);
    endtask

    // model of the address decision: bit1 claimed, bit0 ack, cmd 1 set,2 clr,3 perm
    function automatic logic [3:0] model_addr(input logic [7:0] b, input logic [2:0] p,
                                              input logic hv, input logic perm);
        logic [1:0] c;
        logic ok;
        if (b[7:4] != 4'b0110) return 4'b0000;
        c = (p[2:1] == 2'b00) ? 2'd1 : (p[2:1] == 2'b01) ? 2'd2 :
            (p[2:1] == 2'b10) ? 2'd3 : 2'd0;
        ok = hv && p[0] && (b[3:1] == p) && !b[0] && (c != 2'd0)
             && !(perm && (c == 2'd1 || c == 2'd3));
        return {ok ? c : 2'd0, 1'b1, ok};
    endfunction

    // full well-formed command with given pins; model decides everything
    task automatic run_cmd(input logic [7:0] addr, input logic [2:0] p, input logic hv,
                           input string tag);
        logic [3:0] d;
        pin_lvl = p; a0_hv = hv;
        d = model_addr(addr, p, hv, m_perm);
        do_start();
        send_byte(addr, d[1], d[0], {tag, " addr"});
        send_byte($urandom, d[0], d[0] && hv, {tag, " word"});
        send_byte($urandom, d[0], d[0] && hv, {tag, " data"});
        do_stop();
        if (d[0] && hv) begin
            if (d[3:2] == 2'd1) m_sw = 1'b1;
            if (d[3:2] == 2'd2) m_sw = 1'b0;
            if (d[3:2] == 2'd3) m_perm = 1'b1;
        end
        chk_flags(tag);
    endtask

    initial begin
        logic [3:0] d;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        chk_flags("R10 reset state");
        chk("R11 reset ack_vld", ack_vld, 1'b0);

        run_cmd(8'b0110_0010, 3'b001, 1'b1, "R2 set sw");
        run_cmd(8'b0110_0110, 3'b011, 1'b1, "R3 clear sw");
        run_cmd(8'b0110_0010, 3'b001, 1'b1, "R2 set sw again");
        run_cmd(8'b0110_0110, 3'b011, 1'b0, "R5 clear no hv");
        run_cmd(8'b0110_0111, 3'b011, 1'b1, "R5 read bit");
        run_cmd(8'b0110_0010, 3'b011, 1'b1, "R5 bits mismatch");
        run_cmd(8'b0110_0110, 3'b010, 1'b1, "R5 a0 low");
        run_cmd(8'b0110_1110, 3'b111, 1'b1, "R5 pins 11");
        run_cmd(8'b1010_0110, 3'b011, 1'b1, "R1 foreign code");
        run_cmd(8'b0110_0110, 3'b011, 1'b1, "R3 clear sw again");

        // R7 early stop after word byte
        pin_lvl = 3'b001; a0_hv = 1'b1;
        do_start();
        send_byte(8'b0110_0010, 1'b1, 1'b1, "R7 early stop addr");
        send_byte(8'h55, 1'b1, 1'b1, "R7 early stop word");
        do_stop();
        chk_flags("R7 early stop");

        // R7 repeated start after data then stop
        do_start();
        send_byte(8'b0110_0010, 1'b1, 1'b1, "R7 rstart addr");
        send_byte(8'h12, 1'b1, 1'b1, "R7 rstart word");
        send_byte(8'h34, 1'b1, 1'b1, "R7 rstart data");
        do_start();
        do_stop();
        chk_flags("R7 repeated start");

        // R7 extra byte NACKed
        do_start();
        send_byte(8'b0110_0010, 1'b1, 1'b1, "R7 extra addr");
        send_byte(8'h00, 1'b1, 1'b1, "R7 extra word");
        send_byte(8'hFF, 1'b1, 1'b1, "R7 extra data");
        send_byte(8'hA5, 1'b1, 1'b0, "R7 extra byte");
        do_stop();
        chk_flags("R7 extra byte");

        // R8 high voltage lost on data byte
        do_start();
        send_byte(8'b0110_0010, 1'b1, 1'b1, "R8 addr");
        send_byte(8'h00, 1'b1, 1'b1, "R8 word");
        a0_hv = 1'b0;
        send_byte(8'h00, 1'b1, 1'b0, "R8 data no hv");
        a0_hv = 1'b1;
        do_stop();
        chk_flags("R8 abort");

        // R11 flag timing: sw rises at the edge that samples the stop
        do_start();
        send_byte(8'b0110_0010, 1'b1, 1'b1, "R11 addr");
        send_byte(8'h00, 1'b1, 1'b1, "R11 word");
        send_byte(8'h00, 1'b1, 1'b1, "R11 data");
        @(negedge clk); i2c_stop = 1'b1;
        chk("R11 sw before stop edge", sw_wp, 1'b0);
        @(negedge clk); i2c_stop = 1'b0;
        chk("R11 sw after stop edge", sw_wp, 1'b1);
        m_sw = 1'b1;

        // R10 functional reset clears sw
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_sw = 1'b0;
        chk_flags("R10 rst_n");

        // random transactions against the model (perm kept off)
        for (int i = 0; i < 300; i++) begin
            logic [7:0] a;
            logic [2:0] p;
            logic hv;
            int nb, endk;
            logic alive;
            p  = $urandom_range(0, 7);
            hv = ($urandom_range(0, 9) != 0);
            if (p[2:1] == 2'b10) p[2] = 1'b0;
            a  = ($urandom_range(0, 3) != 0) ? {4'b0110, p, 1'b0} : 8'($urandom);
            if ($urandom_range(0, 7) == 0) a[0] = 1'b1;
            nb = $urandom_range(1, 4);
            endk = $urandom_range(0, 3);
            pin_lvl = p; a0_hv = hv;
            d = model_addr(a, p, hv, m_perm);
            do_start();
            send_byte(a, d[1], d[0], "R5 rnd addr");
            alive = d[0];
            for (int k = 1; k < nb; k++) begin
                logic h2;
                h2 = ($urandom_range(0, 9) != 0);
                a0_hv = h2;
                if (k < 3) begin
                    send_byte(8'($urandom), alive, alive && h2, "R8 rnd byte");
                    alive = alive && h2;
                end else begin
                    send_byte(8'($urandom), alive, 1'b0, "R7 rnd extra");
                    alive = 1'b0;
                end
            end
            if (endk == 0) do_start();
            do_stop();
            if (alive && nb == 3 && endk != 0) begin
                if (d[3:2] == 2'd1) m_sw = 1'b1;
                if (d[3:2] == 2'd2) m_sw = 1'b0;
            end
            chk_flags("R7 rnd");
        end

        // permanent protection
        run_cmd(8'b0110_0010, 3'b001, 1'b1, "R2 set sw before perm");
        run_cmd(8'b0110_1010, 3'b101, 1'b1, "R4 set perm");
        run_cmd(8'b0110_0110, 3'b011, 1'b1, "R6 clear under perm");
        run_cmd(8'b0110_0010, 3'b001, 1'b1, "R6 set sw under perm");
        run_cmd(8'b0110_1010, 3'b101, 1'b1, "R6 perm again");
        run_cmd(8'b0110_0110, 3'b011, 1'b1, "R3 clear keeps perm");

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_sw = 1'b0;
        chk_flags("R10 rst_n keeps perm");

        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        m_sw = 1'b0; m_perm = 1'b0;
        chk_flags("R10 por_n clears perm");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule